// File: doc/BRIEF.md
# Control register pair with per-field write precedence and event counters

This block holds two control bits and two read-only event counters behind a simple full-width CPU read/write port. Both control bits can be written by software through the port and by hardware logic through a per-bit write-enable and next-value pair. When both sides write the same bit in the same clock, a build-time choice for each bit decides the winner. Bit A lets software win. Bit B lets hardware win.

Each control bit drives a 4-bit counter. The counter advances on every clock edge at which its bit holds 1. Software can therefore see how many cycles a bit stayed set, which shows the result of each collision. Register offsets are byte addresses aligned to the register width. Every access covers the full register. The CPU data width equals the register width.

Top module: `csr_prio_block`

## Requirements
- R1: After a synchronous active-high reset, both control bits and both counters are 0 and `cpu_ack` is low.
- R2: A software write to offset 0x0 loads `cpu_wdata[0]` into bit A and `cpu_wdata[1]` into bit B when no hardware write-enable is active. The new value reads back from the next cycle on. Offset 0x0 reads bit A in bit 0, bit B in bit 1, and zeros elsewhere.
- R3: When hardware writes bit A with its enable high in the same cycle as a software write to offset 0x0, bit A takes the software value. A hardware write alone loads `hw_a_next`.
- R4: When hardware writes bit B with its enable high in the same cycle as a software write to offset 0x0, bit B takes `hw_b_next` and the software value is lost.
- R5: While a hardware write-enable is low, its next-value input has no effect on the bit.
- R6: Offset 0x4 reads counter A in bits [3:0] and counter B in bits [7:4], with zeros above. Software writes to offset 0x4 change nothing.
- R7: A counter increments by one on each clock edge at which its bit is 1. A bit set at one edge is first counted at the following edge.
- R8: A counter wraps from 15 to 0.
- R9: An access to any address other than exactly 0x0 or 0x4, including a misaligned one, reads as 0, and a write to it changes nothing.
- R10: A read request is acknowledged with `cpu_ack` and its data exactly one cycle after the request. `cpu_ack` is low in every other cycle, including after writes.
- R11: With hardware writing 0 to both bits every cycle, three software writes of 0b11 to offset 0x0 leave offset 0x0 reading 0 and offset 0x4 reading 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access request, sampled each clock |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (4) | Byte address |
| cpu_wdata | input | DATA_W (32) | Write data, full width |
| cpu_ack | output | 1 | Read acknowledge, one cycle after the read request |
| cpu_rdata | output | DATA_W (32) | Read data, valid with `cpu_ack` |
| hw_a_we | input | 1 | Hardware write-enable for bit A |
| hw_a_next | input | 1 | Hardware value for bit A |
| hw_b_we | input | 1 | Hardware write-enable for bit B |
| hw_b_next | input | 1 | Hardware value for bit B |

## Verification
A wrong control bit shows up on a read of offset 0x0 in the cycle after the edge that stored it. One cycle later it also shows in the counter's pace at offset 0x4. The counters accumulate every cycle the bits spend set. A single-cycle precedence error therefore stays visible as a permanent count offset, long after the bit itself has been overwritten. The bench places its reads at exact cycles so that each collision can be attributed to one edge.

// File: rtl/csr_prio_pkg.sv
package csr_prio_pkg;
    localparam int NUM_BITS = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CNT  = 2'd2
    } sel_e;
endpackage

// File: rtl/csr_prio_field.sv
module csr_prio_field #(
    parameter bit SW_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_we,
    input  logic sw_val,
    input  logic hw_we,
    input  logic hw_val,
    output logic q
);
    typedef struct packed {
        logic v;
    } state_t;

    state_t s_d, s_q;
    logic   win_sw;

    // precedence variant picked by parameter
    generate
        if (SW_WINS) begin : g_sw_first
            assign win_sw = sw_we;
        end else begin : g_hw_first
            assign win_sw = sw_we & ~hw_we;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (win_sw) begin
            s_d.v = sw_val;
        end else if (hw_we) begin
            s_d.v = hw_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q = s_q.v;
endmodule

// File: rtl/csr_prio_counter.sv
module csr_prio_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inc) s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign q = s_q.cnt;
endmodule

// File: rtl/csr_prio_rdport.sv
module csr_prio_rdport
    import csr_prio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NB     = 2,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  sel_e                sel,
    input  logic [NB-1:0]       bits,
    input  logic [NB*CNT_W-1:0] cnts,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata
);
    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = '0;
        s_d.ack  = rd_en;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL: s_d.data[NB-1:0]       = bits;
                SEL_CNT:  s_d.data[NB*CNT_W-1:0] = cnts;
                default:  s_d.data               = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ack   = s_q.ack;
    assign rdata = s_q.data;
endmodule

// File: rtl/csr_prio_block.sv
module csr_prio_block
    import csr_prio_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 4,
    parameter int          CNT_W   = 4,
    parameter logic [1:0]  SW_WINS = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hw_a_we,
    input  logic              hw_a_next,
    input  logic              hw_b_we,
    input  logic              hw_b_next
);
    localparam int                NB       = NUM_BITS;
    localparam int                REG_B    = DATA_W / 8;
    localparam logic [ADDR_W-1:0] OFS_CTRL = '0;
    localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(REG_B);

    sel_e                sel;
    logic                sw_we;
    logic                rd_en;
    logic [NB-1:0]       hw_we_v;
    logic [NB-1:0]       hw_val_v;
    logic [NB-1:0]       fld_q;
    logic [NB*CNT_W-1:0] cnt_q;

    always_comb begin
        if (cpu_addr == OFS_CTRL)     sel = SEL_CTRL;
        else if (cpu_addr == OFS_CNT) sel = SEL_CNT;
        else                          sel = SEL_NONE;
    end

    assign sw_we    = cpu_req & cpu_wr & (sel == SEL_CTRL);
    assign rd_en    = cpu_req & ~cpu_wr;
    assign hw_we_v  = {hw_b_we, hw_a_we};
    assign hw_val_v = {hw_b_next, hw_a_next};

    generate
        for (genvar i = 0; i < NB; i++) begin : g_bit
            csr_prio_field #(.SW_WINS(SW_WINS[i])) u_fld (
                .clk    (clk),
                .rst    (rst),
                .sw_we  (sw_we),
                .sw_val (cpu_wdata[i]),
                .hw_we  (hw_we_v[i]),
                .hw_val (hw_val_v[i]),
                .q      (fld_q[i])
            );
            csr_prio_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .inc (fld_q[i]),
                .q   (cnt_q[i*CNT_W +: CNT_W])
            );
        end
    endgenerate

    csr_prio_rdport #(.DATA_W(DATA_W), .NB(NB), .CNT_W(CNT_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .sel   (sel),
        .bits  (fld_q),
        .cnts  (cnt_q),
        .ack   (cpu_ack),
        .rdata (cpu_rdata)
    );
endmodule

// File: rtl/csr_prio_block_chk.sv
module csr_prio_block_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cpu_req,
    input logic                cpu_wr,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic                cpu_ack,
    input logic [DATA_W-1:0]   cpu_rdata,
    input logic                hw_b_we,
    input logic                hw_b_next,
    input logic [1:0]          fld_q,
    input logic [2*CNT_W-1:0]  cnt_q
);
    localparam logic [ADDR_W-1:0] A_CTRL = '0;
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(DATA_W / 8);

    logic [CNT_W-1:0] ca, ca_inc;
    assign ca     = cnt_q[CNT_W-1:0];
    assign ca_inc = ca + CNT_W'(1);

    // R10
    read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_wr) |=> cpu_ack);

    // R10
    quiet_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_req && !cpu_wr) |=> !cpu_ack);

    // R3
    sw_first_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_wr && cpu_addr == A_CTRL) |=> fld_q[0] == $past(cpu_wdata[0]));

    // R4
    hw_first_b_chk: assert property (@(posedge clk) disable iff (rst)
        hw_b_we |=> fld_q[1] == $past(hw_b_next));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        fld_q[0] |=> ca == $past(ca_inc));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fld_q[0] |=> $stable(ca));

    // R8
    count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fld_q[0] && ca == {CNT_W{1'b1}}) |=> ca == '0);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_wr && cpu_addr != A_CTRL && cpu_addr != A_CNT) |=> cpu_rdata == '0);
endmodule

bind csr_prio_block csr_prio_block_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .hw_b_we   (hw_b_we),
    .hw_b_next (hw_b_next),
    .fld_q     (fld_q),
    .cnt_q     (cnt_q)
);

// File: tb/csr_prio_block_test.sv
module csr_prio_block_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        hw_a_we = 1'b0;
    logic        hw_a_next = 1'b0;
    logic        hw_b_we = 1'b0;
    logic        hw_b_next = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] q_data[$];
    int          q_cyc[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    csr_prio_block uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .hw_a_we(hw_a_we), .hw_a_next(hw_a_next),
        .hw_b_we(hw_b_we), .hw_b_next(hw_b_next)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the scoreboard when an acknowledge appears
    always @(posedge clk) begin
        #2;
        if (rst) begin
            check(cpu_ack == 1'b0, "R1 ack low in reset", 32'(cpu_ack), 32'd0);
        end else if (cpu_ack) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R10 unexpected ack", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] d = q_data.pop_front();
                automatic int          c = q_cyc.pop_front();
                automatic string       t = q_tag.pop_front();
                check(c == cyc, {t, " ack cycle"}, 32'(cyc), 32'(c));
                check(cpu_rdata == d, t, cpu_rdata, d);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_req = 1'b0;
        cpu_wr  = 1'b0;
    endtask

    task automatic set_wr(input logic [3:0] a, input logic [31:0] d);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    endtask

    task automatic set_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        q_data.push_back(e);
        q_cyc.push_back(cyc + 1);
        q_tag.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset values
        set_rd(4'h0, 32'h0, "R1 ctrl reset"); tick();
        set_rd(4'h4, 32'h0, "R1 counters reset"); tick();
        idle(); tick();

        // R11 hardware writes 0 every cycle, software writes 0b11 three times
        hw_a_we = 1; hw_a_next = 0; hw_b_we = 1; hw_b_next = 0; tick();
        set_wr(4'h0, 32'h3); tick();
        set_wr(4'h0, 32'h3); tick();
        set_wr(4'h0, 32'h3); tick();
        idle(); tick(); tick();
        set_rd(4'h0, 32'h0, "R11 ctrl"); tick();
        set_rd(4'h4, 32'h03, "R11 counters"); tick();
        idle(); hw_a_we = 0; hw_b_we = 0; tick();

        // R2 / R5: software only, hardware values 1 with enables low
        hw_a_next = 1; hw_b_next = 1;
        set_wr(4'h0, 32'h3); tick();
        set_wr(4'h0, 32'h0); tick();
        idle(); tick();
        set_rd(4'h0, 32'h0, "R5 disabled hw ignored"); tick();
        set_rd(4'h4, 32'h14, "R2 R6 one cycle set"); tick();
        set_wr(4'h0, 32'h1); tick();
        set_rd(4'h0, 32'h1, "R2 readback"); tick();
        set_wr(4'h0, 32'h0); tick();
        idle(); tick();

        // R3 / R4 collision: hw writes 1, sw writes 0
        hw_a_we = 1; hw_a_next = 1; hw_b_we = 1; hw_b_next = 1;
        set_wr(4'h0, 32'h0); tick();
        hw_a_we = 0; hw_b_we = 0;
        set_rd(4'h0, 32'h2, "R3 R4 collision"); tick();
        set_wr(4'h0, 32'h0); tick();
        idle(); tick();
        set_rd(4'h4, 32'h36, "R7 counts after collision"); tick();
        idle(); tick();

        // R3 hardware-only write to bit A
        hw_a_we = 1; hw_a_next = 1; tick();
        hw_a_we = 0;
        set_rd(4'h0, 32'h1, "R3 hw alone"); tick();
        hw_a_we = 1; hw_a_next = 0; idle(); tick();
        hw_a_we = 0; tick();

        // R8 wrap: bit A held for 10 counted edges, 8 + 10 = 18 -> 2
        set_wr(4'h0, 32'h1); tick();
        idle();
        repeat (9) tick();
        set_wr(4'h0, 32'h0); tick();
        idle(); tick();
        set_rd(4'h4, 32'h32, "R8 wrap"); tick();
        idle(); tick();

        // R9 / R6 ignored writes and unmapped reads
        set_wr(4'h8, 32'h3); tick();
        set_wr(4'h1, 32'h3); tick();
        set_wr(4'h4, 32'hFFFF_FFFF); tick();
        idle(); tick();
        set_rd(4'h0, 32'h0, "R9 writes elsewhere ignored"); tick();
        set_rd(4'h8, 32'h0, "R9 unmapped read"); tick();
        set_rd(4'h1, 32'h0, "R9 misaligned read"); tick();
        set_rd(4'h4, 32'h32, "R6 counters read-only"); tick();
        idle();
        repeat (3) tick();

        // R10 every read produced exactly one ack
        check(q_data.size() == 0, "R10 missing ack", 32'(q_data.size()), 32'd0);
        finish_run();
    end
endmodule